// File: doc/BRIEF.md
# Wiper Position Readback Slave

This block is a two-wire serial bus slave that keeps the current tap setting of three digital potentiometers and lets a bus master read any one of them back. The potentiometers differ in resolution: one has 64 taps, one has 100 taps and one has 256 taps. Each register therefore stores 6, 7 or 8 bits.

A read takes two steps. The master first sends the write-direction address and an instruction byte, with no data after it, which chooses the register. It then issues a repeated START and the read-direction address. The slave answers with one byte, most significant bit first. Bits that lie above a register's width come back as zero.

SCL and SDA are oversampled on the system clock. The slave pulls the line low by asserting an open-drain enable. The registers are loaded from a plain parallel host port.

Top module: `i2c_wiper_rb`

## Requirements
- R1: The write-direction address byte 0xAE (7-bit address 1010111, R/W bit 0) is acknowledged: sda_oe is 1 for the whole of the ninth SCL pulse.
- R2: Any other first byte after a START is not acknowledged. This includes the memory-array identifiers 0xA0 and 0xA1 and the neighbour address 0xAC. sda_oe then stays 0 until the next START.
- R3: The instruction byte is laid out as bit 7 = write flag, bits 6:2 = zero, bits 1:0 = register select. It is acknowledged only when bits 6:2 are all zero and the select is 0, 1 or 2. Any other value gets no acknowledge, and the slave goes idle.
- R4: The write flag in bit 7 of the instruction byte has no effect on the acknowledge or on which register is read.
- R5: The read-direction address byte 0xAF is acknowledged. The slave then drives eight data bits, MSB first, in which sda_oe = 1 sends a 0 bit. These bits are the register chosen by the latest valid instruction byte.
- R6: The 64-tap register reads back with bits 7:6 = 0. The 100-tap register reads back with bit 7 = 0. The 256-tap register returns all eight stored bits.
- R7: A read that is not immediately preceded by a valid instruction byte returns register 0. A selection is used by one read only.
- R8: A STOP, or a START that arrives anywhere other than right after an acknowledged instruction byte, ends the transfer. It also releases SDA and cancels the pending selection.
- R9: After the eighth data bit, SDA is released for the master's acknowledge bit. It stays released until STOP or START.
- R10: A host_we pulse writes host_data into register host_sel (0, 1 or 2), keeping its low 6, 7 or 8 bits. A write with host_sel = 3 changes no register.
- R11: sda_oe is 0 during reset. It changes only while SCL is low, except when it is released by START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| host_we | input | 1 | Register write strobe |
| host_sel | input | 2 | Register index for a host write |
| host_data | input | 8 | Host write value |

## Verification
The readback transaction is run with all-ones register contents, which shows the zeroed upper bits of each width. It is also run with alternating and mixed patterns, which show the bit order and that the right register is selected.

Instruction bytes are tried with the write flag set and cleared, with select value 3, and with a stray bit in the reserved field. Together these separate the flag that is ignored from the fields that are checked.

Further sequences cover:
- a read with no instruction byte before it, and a second read that reuses an old selection;
- a STOP, and a START in the middle of a byte, between the setup and the read;
- foreign addresses, including the memory identifiers.

These sequences show whether the selection is kept, consumed or dropped in each case.

// File: rtl/i2c_wiper_rb.sv
module i2c_wiper_rb #(
  parameter logic [6:0] DEV_ADDR = 7'h57,
  parameter int W0_BITS = 6,
  parameter int W1_BITS = 7,
  parameter int W2_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       host_we,
  input  logic [1:0] host_sel,
  input  logic [7:0] host_data
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_HOLD, S_TX, S_MACK, S_WAIT} st_t;
  typedef enum logic [1:0] {N_INSTR, N_HOLD, N_TX} nx_t;

  localparam logic [7:0] WR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [7:0] RD_BYTE = {DEV_ADDR, 1'b1};

  logic [2:0] scl_q, sda_q;
  st_t        state;
  nx_t        after;
  logic       is_instr, armed;
  logic [3:0] cnt;
  logic [7:0] shreg, txreg;
  logic [1:0] ptr;
  logic [W0_BITS-1:0] w0;
  logic [W1_BITS-1:0] w1;
  logic [W2_BITS-1:0] w2;

  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire scl_hi    = scl_q[1] & scl_q[2];
  wire start_det = scl_hi & ~sda_q[1] & sda_q[2];
  wire stop_det  = scl_hi & sda_q[1] & ~sda_q[2];
  wire instr_ok  = (shreg[6:2] == 5'd0) && (shreg[1:0] != 2'b11);

  wire [7:0] rd0 = 8'(w0);
  wire [7:0] rd1 = 8'(w1);
  wire [7:0] rd2 = 8'(w2);
  wire [7:0] sel_val = !armed      ? rd0 :
                       (ptr == 2'd1) ? rd1 :
                       (ptr == 2'd2) ? rd2 : rd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0 <= '0;
      w1 <= '0;
      w2 <= '0;
    end else if (host_we) begin
      case (host_sel)
        2'd0: w0 <= host_data[W0_BITS-1:0];
        2'd1: w1 <= host_data[W1_BITS-1:0];
        2'd2: w2 <= host_data[W2_BITS-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      after    <= N_INSTR;
      is_instr <= 1'b0;
      armed    <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      txreg    <= '0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
    end else if (stop_det) begin
      state  <= S_IDLE;
      armed  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state    <= S_RX;
      is_instr <= 1'b0;
      cnt      <= '0;
      sda_oe   <= 1'b0;
      if (state != S_HOLD) armed <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_q[1]};
            cnt   <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (!is_instr) begin
              if (shreg == WR_BYTE) begin
                sda_oe <= 1'b1;
                state  <= S_ACK;
                after  <= N_INSTR;
              end else if (shreg == RD_BYTE) begin
                sda_oe <= 1'b1;
                state  <= S_ACK;
                after  <= N_TX;
                txreg  <= sel_val;
                armed  <= 1'b0;
              end else begin
                state <= S_IDLE;
              end
            end else if (instr_ok) begin
              sda_oe <= 1'b1;
              state  <= S_ACK;
              after  <= N_HOLD;
              ptr    <= shreg[1:0];
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            case (after)
              N_INSTR: begin
                state    <= S_RX;
                is_instr <= 1'b1;
                cnt      <= '0;
                sda_oe   <= 1'b0;
              end
              N_HOLD: begin
                state  <= S_HOLD;
                armed  <= 1'b1;
                sda_oe <= 1'b0;
              end
              default: begin
                state  <= S_TX;
                cnt    <= '0;
                sda_oe <= ~txreg[7];
              end
            endcase
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              state  <= S_MACK;
              sda_oe <= 1'b0;
            end else begin
              txreg  <= {txreg[6:0], 1'b0};
              cnt    <= cnt + 4'd1;
              sda_oe <= ~txreg[6];
            end
          end
        end
        S_MACK: if (scl_rise) state <= S_WAIT;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_wiper_rb_chk.sv
module i2c_wiper_rb_chk #(
  parameter int W0_BITS = 6,
  parameter int W1_BITS = 7,
  parameter int W2_BITS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_i,
  input logic               sda_oe,
  input logic               host_we,
  input logic [1:0]         host_sel,
  input logic               start_det,
  input logic               stop_det,
  input logic [W0_BITS-1:0] w0,
  input logic [W1_BITS-1:0] w1,
  input logic [W2_BITS-1:0] w2
);

  a_r11_reset_released: assert property (@(posedge clk) !rst_n |=> !sda_oe);

  a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_i);

  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  a_r8_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  a_r10_sel3_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel == 2'd3) |=> ($stable(w0) && $stable(w1) && $stable(w2)));

endmodule

bind i2c_wiper_rb i2c_wiper_rb_chk #(
  .W0_BITS(W0_BITS), .W1_BITS(W1_BITS), .W2_BITS(W2_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .host_we(host_we), .host_sel(host_sel),
  .start_det(start_det), .stop_det(stop_det),
  .w0(w0), .w1(w1), .w2(w2)
);

// File: tb/sim_i2c_wiper_rb.sv
`timescale 1ns/1ps
module sim_i2c_wiper_rb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic host_we = 1'b0;
  logic [1:0] host_sel = '0;
  logic [7:0] host_data = '0;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  int nchk = 0, nerr = 0;
  int mw [3] = '{0, 0, 0};
  int mask [3] = '{8'h3F, 8'h7F, 8'hFF};
  bit m_armed = 0, m_hold = 0;
  int m_ptr = 0;

  always #2 clk = ~clk;

  i2c_wiper_rb u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .host_we(host_we), .host_sel(host_sel), .host_data(host_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: sda_oe got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  task automatic bus_bit(input logic b, input logic exp_oe, input string tag);
    tick(1); m_sda = b; tick(5);
    m_scl = 1'b1; tick(1);
    for (int k = 0; k < 5; k++) begin chk(sda_oe, exp_oe, tag); tick(1); end
    m_scl = 1'b0;
  endtask

  task automatic bus_start();
    tick(1); m_sda = 1'b1; tick(3); m_scl = 1'b1; tick(6);
    m_sda = 1'b0; tick(6); m_scl = 1'b0; tick(2);
    if (!m_hold) m_armed = 0;
    m_hold = 0;
  endtask

  task automatic bus_stop();
    tick(1); m_sda = 1'b0; tick(3); m_scl = 1'b1; tick(6);
    m_sda = 1'b1; tick(6);
    chk(sda_oe, 1'b0, "R8 released after stop");
    m_armed = 0; m_hold = 0;
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic ack, input string tag);
    for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, tag);
    bus_bit(1'b1, ack, tag);
  endtask

  task automatic rd_byte(input logic [7:0] exp, input string tag);
    for (int i = 7; i >= 0; i--) bus_bit(1'b1, ~exp[i], tag);
    bus_bit(1'b1, 1'b0, "R9 released for master ack");
  endtask

  task automatic host_write(input int sel, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = 2'(sel); host_data = d;
    @(negedge clk);
    host_we = 1'b0;
    if (sel < 3) mw[sel] = d & mask[sel];
  endtask

  task automatic do_read(input string tag);
    logic [7:0] exp;
    bus_start();
    wr_byte(8'hAF, 1'b1, "R5 read address ack");
    exp = m_armed ? 8'(mw[m_ptr]) : 8'(mw[0]);
    m_armed = 0;
    rd_byte(exp, tag);
    bus_stop();
  endtask

  task automatic setup(input logic [7:0] instr, input string tag);
    logic ok;
    ok = (instr[6:2] == 5'd0) && (instr[1:0] != 2'b11);
    bus_start();
    wr_byte(8'hAE, 1'b1, "R1 write address ack");
    wr_byte(instr, ok, tag);
    if (ok) begin m_armed = 1; m_hold = 1; m_ptr = int'(instr[1:0]); end
  endtask

  task automatic readback(input logic [7:0] instr, input string tag);
    setup(instr, tag);
    do_read(tag);
  endtask

  initial begin
    tick(3);
    chk(sda_oe, 1'b0, "R11 reset");
    rst_n = 1'b1;
    tick(4);
    chk(sda_oe, 1'b0, "R11 idle after reset");

    host_write(0, 8'hFF); host_write(1, 8'hFF); host_write(2, 8'hFF);
    readback(8'h00, "R6 reg0 upper bits zero");
    readback(8'h01, "R6 reg1 msb zero");
    readback(8'h02, "R6 reg2 full byte");

    host_write(0, 8'hA5); host_write(1, 8'h5A); host_write(2, 8'hC3);
    readback(8'h02, "R5 reg2 pattern");
    readback(8'h01, "R5 reg1 pattern");
    readback(8'h00, "R5 reg0 pattern");
    readback(8'h82, "R4 write flag set reg2");
    readback(8'h81, "R4 write flag set reg1");

    host_write(3, 8'h00);
    readback(8'h02, "R10 sel3 ignored reg2");
    readback(8'h01, "R10 sel3 ignored reg1");
    readback(8'h00, "R10 sel3 ignored reg0");

    readback(8'h03, "R3 select 3 rejected");
    readback(8'h06, "R3 reserved bit rejected");
    readback(8'h80, "R3 reserved field zero ok");

    do_read("R7 read without setup");
    setup(8'h02, "R7 setup for reuse");
    do_read("R7 first read uses selection");
    do_read("R7 second read falls back to reg0");

    setup(8'h02, "R8 setup then stop");
    bus_stop();
    do_read("R8 stop dropped selection");

    bus_start();
    wr_byte(8'hAE, 1'b1, "R1 write address ack");
    for (int i = 0; i < 4; i++) bus_bit(1'b0, 1'b0, "R8 partial instruction");
    do_read("R8 mid-byte start dropped selection");

    bus_start();
    wr_byte(8'hA0, 1'b0, "R2 memory write id");
    wr_byte(8'h02, 1'b0, "R2 stays released");
    bus_stop();
    bus_start();
    wr_byte(8'hA1, 1'b0, "R2 memory read id");
    wr_byte(8'hFF, 1'b0, "R2 stays released");
    bus_stop();
    bus_start();
    wr_byte(8'hAC, 1'b0, "R2 neighbour address");
    bus_stop();

    host_write(2, 8'h3C);
    readback(8'h02, "R10 host rewrite reg2");

    summary();
  end

  initial begin
    #(4 * 150000);
    nerr++;
    $display("FAIL watchdog: run did not finish, got=hung exp=done");
    summary();
  end
endmodule